// File: doc/BRIEF.md
# Auto-Reload Interval Down-Counter

This block is a register-mapped interval timer with a small bus for word reads and writes. Software writes a start value into the reload register, and that value goes straight into the counter. Software then sets the run flag, the reload-mode flag and the tick-select flag in the control word. While running, the counter steps down by one on every strobe from the selected tick input.

When the counter steps down from zero, the block raises a sticky interrupt. In periodic mode the counter then takes the reload value and keeps going. In free-running mode it wraps to all ones. A write of any data to the acknowledge register drops the interrupt.

The two tick inputs are single-cycle clock-enable strobes made elsewhere: a fast one of about 508 kHz and a slower one. The counter width is a parameter, typically 16 or 32 bits. Register reads are combinational on the address.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, the reload, count and control registers all read zero, and `irq` is low.
- R2: A write to the reload register (byte offset 0x00) stores the low CNT_W bits of the data. In the cycle after the write, the count register (offset 0x04) shows that same value. Bits above CNT_W read as zero in both registers.
- R3: The control register (offset 0x08) keeps only bit 7 (run), bit 6 (periodic) and bit 3 (fast tick select). All other bits read as zero.
- R4: While the run bit is clear, strobes on either tick input leave the count unchanged.
- R5: With run set and bit 3 set, each `tick_fast` strobe lowers the count by one, and `tick_slow` has no effect.
- R6: With run set and bit 3 clear, each `tick_slow` strobe lowers the count by one, and `tick_fast` has no effect.
- R7: In periodic mode (bit 6 set), a selected tick while the count is zero loads the count from the reload register and sets `irq` in the next cycle. A start value of N therefore raises `irq` on tick N+1.
- R8: In free-running mode (bit 6 clear), a selected tick while the count is zero wraps the count to all ones (0xFFFF for a 16-bit counter) and sets `irq`.
- R9: Once `irq` is set, it stays set through further underflows until an acknowledge write arrives.
- R10: A write of any data value to offset 0x0C clears `irq` in the next cycle. If an underflow happens in the same cycle, the underflow wins and `irq` stays set.
- R11: Writing zero to the control register stops counting. Writing a new reload value and then setting run starts counting again from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| tick_fast | input | 1 | Fast tick strobe, one clock wide |
| tick_slow | input | 1 | Slow tick strobe, one clock wide |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
If the count register holds a wrong value, it shows on the very next read of offset 0x04. It also shows as `irq` rising one tick early or late. A wrong tick-select or run decode shows one strobe later as a count that moved when it should not have, or held when it should have moved. A wrong reload or wrap value shows on the cycle after the underflow tick. A lost or unclearable interrupt flag shows at `irq` one cycle after the underflow or the acknowledge write.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam int BIT_RUN      = 7;
    localparam int BIT_PERIODIC = 6;
    localparam int BIT_FAST     = 3;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_ACK    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic periodic;
        logic fast_sel;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run      = w[BIT_RUN];
        c.periodic = w[BIT_PERIODIC];
        c.fast_sel = w[BIT_FAST];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_RUN]      = c.run;
        w[BIT_PERIODIC] = c.periodic;
        w[BIT_FAST]     = c.fast_sel;
        return w;
    endfunction

    function automatic reg_sel_e reg_decode(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/rtmr_regs.sv
module rtmr_regs
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  reload,
    output ctrl_t             ctrl,
    output logic              reload_wr,
    output logic              ack_wr
);

    reg_sel_e          sel;
    logic              wr_en;
    logic [DATA_W-1:0] reload_ext;
    logic [DATA_W-1:0] count_ext;

    assign sel       = reg_decode(bus_addr);
    assign wr_en     = bus_sel && bus_wr;
    assign reload_wr = wr_en && (sel == REG_RELOAD);
    assign ack_wr    = wr_en && (sel == REG_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            ctrl   <= '0;
        end else begin
            if (reload_wr)
                reload <= bus_wdata[CNT_W-1:0];
            if (wr_en && (sel == REG_CTRL))
                ctrl <= ctrl_unpack(bus_wdata);
        end
    end

    generate
        if (CNT_W < DATA_W) begin : g_pad
            assign reload_ext = {{(DATA_W-CNT_W){1'b0}}, reload};
            assign count_ext  = {{(DATA_W-CNT_W){1'b0}}, count};
        end else begin : g_full
            assign reload_ext = reload;
            assign count_ext  = count;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            REG_RELOAD: bus_rdata = reload_ext;
            REG_COUNT:  bus_rdata = count_ext;
            REG_CTRL:   bus_rdata = ctrl_pack(ctrl);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtmr_count.sv
module rtmr_count
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_data,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic step;
    logic at_zero;

    assign step      = ctrl.run && (ctrl.fast_sel ? tick_fast : tick_slow);
    assign at_zero   = (count == '0);
    assign underflow = step && at_zero && !reload_wr;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (reload_wr)
            count <= reload_data;
        else if (underflow)
            count <= ctrl.periodic ? reload : ALL_ONES;
        else if (step)
            count <= count - 1'b1;
    end

endmodule

// File: rtl/rtmr_irq.sv
module rtmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_q;
    ctrl_t            ctl_q;
    logic             ld_wr;
    logic             ack;
    logic             uflow;

    rtmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count_q),
        .bus_rdata (bus_rdata),
        .reload    (load_q),
        .ctrl      (ctl_q),
        .reload_wr (ld_wr),
        .ack_wr    (ack)
    );

    rtmr_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctl_q),
        .tick_fast   (tick_fast),
        .tick_slow   (tick_slow),
        .reload_wr   (ld_wr),
        .reload_data (bus_wdata[CNT_W-1:0]),
        .reload      (load_q),
        .count       (count_q),
        .underflow   (uflow)
    );

    rtmr_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (uflow),
        .clr  (ack),
        .flag (irq)
    );

endmodule

// File: rtl/rtmr_chk.sv
module rtmr_chk
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick_fast,
    input logic              tick_slow,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  ld,
    input ctrl_t             ctl
);

    logic c_ldwr, c_ackwr, c_tick, c_under;

    assign c_ldwr  = bus_sel && bus_wr && (bus_addr[3:2] == 2'd0);
    assign c_ackwr = bus_sel && bus_wr && (bus_addr[3:2] == 2'd3);
    assign c_tick  = ctl.run && (ctl.fast_sel ? tick_fast : tick_slow);
    assign c_under = c_tick && (cnt == '0) && !c_ldwr;

    assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
        c_ldwr |=> cnt == $past(bus_wdata[CNT_W-1:0]));

    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !c_ldwr) |=> $stable(cnt));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (c_under && ctl.periodic) |=> (cnt == $past(ld)) && irq);

    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (c_under && !ctl.periodic) |=> (&cnt) && irq);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !c_ackwr) |=> irq);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (c_ackwr && !c_under) |=> !irq);

endmodule

bind reload_timer rtmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .irq       (irq),
    .cnt       (count_q),
    .ld        (load_q),
    .ctl       (ctl_q)
);

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;

    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    reload_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); check("R1 reload", d, 0);
        rd(4'h4, d); check("R1 count", d, 0);
        rd(4'h8, d); check("R1 ctrl", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_load();
        logic [31:0] d;
        wr(4'h0, 32'h1234_0005);
        rd(4'h4, d); check("R2 count copy", d, 32'h5);
        rd(4'h0, d); check("R2 reload truncated", d, 32'h5);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] d;
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d); check("R3 ctrl mask", d, 32'hC8);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_stopped();
        logic [31:0] d;
        wr(4'h0, 32'd10);
        ticks(1, 3); ticks(0, 3);
        rd(4'h4, d); check("R4 stopped count", d, 32'd10);
    endtask

    task automatic t_fast();
        logic [31:0] d;
        wr(4'h8, 32'hC8);
        wr(4'h0, 32'd10);
        ticks(1, 3);
        rd(4'h4, d); check("R5 fast decrement", d, 32'd7);
        ticks(0, 2);
        rd(4'h4, d); check("R5 slow ignored", d, 32'd7);
    endtask

    task automatic t_slow();
        logic [31:0] d;
        wr(4'h8, 32'hC0);
        wr(4'h0, 32'd10);
        ticks(0, 4);
        rd(4'h4, d); check("R6 slow decrement", d, 32'd6);
        ticks(1, 2);
        rd(4'h4, d); check("R6 fast ignored", d, 32'd6);
    endtask

    task automatic t_reload();
        logic [31:0] d;
        wr(4'h8, 32'hC8);
        wr(4'h0, 32'd2);
        ticks(1, 2);
        check("R7 no irq before underflow", {31'b0, irq}, 0);
        ticks(1, 1);
        rd(4'h4, d); check("R7 reloaded", d, 32'd2);
        check("R7 irq raised", {31'b0, irq}, 1);
        wr(4'hC, 32'h0);
        check("R10 ack clears", {31'b0, irq}, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(4'h8, 32'h88);
        wr(4'h0, 32'd1);
        ticks(1, 2);
        rd(4'h4, d); check("R8 wrap all ones", d, 32'hFFFF);
        check("R8 irq raised", {31'b0, irq}, 1);
        ticks(1, 1);
        rd(4'h4, d); check("R8 after wrap", d, 32'hFFFE);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr(4'h0, 32'd0);
        ticks(1, 1);
        check("R9 irq held", {31'b0, irq}, 1);
        rd(4'h4, d); check("R9 second wrap", d, 32'hFFFF);
        wr(4'hC, 32'hDEAD);
        check("R10 ack any data", {31'b0, irq}, 0);
    endtask

    task automatic t_stop_restart();
        logic [31:0] d;
        wr(4'h8, 32'hC8);
        wr(4'h0, 32'd5);
        ticks(1, 1);
        wr(4'h8, 32'h0);
        ticks(1, 3);
        rd(4'h4, d); check("R11 stopped", d, 32'd4);
        wr(4'h0, 32'd3);
        wr(4'h8, 32'hC8);
        ticks(1, 1);
        rd(4'h4, d); check("R11 restart", d, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_ctrl_mask();
        t_stopped();
        t_fast();
        t_slow();
        t_reload();
        t_wrap();
        t_sticky();
        t_stop_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule